// File: doc/BRIEF.md
# Two-level shadow TLB translator

This block turns 32-bit effective addresses into real addresses for two requesters: an instruction-side fetch port and a data-side load/store port. Pages are 4 KB. The low 12 offset bits pass through unchanged, and the upper 20 bits become a real page number. Each side has a small, fully associative shadow TLB that hardware alone fills and manages. Software cannot see it. Both shadows sit in front of one shared unified TLB, which software loads through a write port that takes an index, a tag, a real page and a valid bit.

When the translation-enable input is low, the effective address is returned as the real address in the same cycle, and no TLB is consulted. When it is high, a hit in the requesting side's shadow answers in the same cycle. A shadow miss hands the request to a walker state machine. The walker searches the unified TLB and answers exactly two cycles later. On a unified hit it returns the translation and copies it into that side's shadow. On a unified miss it raises the miss exception for that side. A requester that misses keeps its request stable until it sees a done or a miss response.

The walker has three states:
- `ST_IDLE` accepts a pending miss, and the data side wins when both sides wait.
- `ST_LOOK` searches the unified TLB with the latched page.
- `ST_RESP` presents the response and performs the refill.

The transitions are:
- IDLE→LOOK on any pending miss.
- LOOK→RESP unconditionally.
- RESP→IDLE unconditionally.

Any software write to the unified TLB, and any change of the enable input, empties both shadows. If that flush arrives while a walk is in flight, the walk still answers but does not refill.

Top module: `xlt_translator`

## Requirements
- R1: With `vm_en` low, a valid request on either side gets `*_rsp_done` high in the same cycle, `*_rsp_ra` equal to `*_req_ea`, and `*_rsp_miss` low.
- R2: With `vm_en` high and the page present in that side's shadow, `*_rsp_done` is high in the same cycle, and `*_rsp_ra` is {shadow real page, ea[11:0]}.
- R3: On a shadow miss that hits in the unified TLB, `*_rsp_done` rises exactly two cycles after the first request cycle, with `*_rsp_ra` = {unified real page, ea[11:0]}. The entry is copied into that side's shadow, so the next access to the page answers in the same cycle.
- R4: On a unified miss, that side's `*_rsp_miss` is high exactly two cycles after the first request cycle, `*_rsp_done` stays low, and nothing is refilled. A repeat of the access misses again with the same latency.
- R5: The two shadows are separate. A refill on one side does not make the other side hit.
- R6: Each shadow holds 4 entries. A refill goes first to the lowest-indexed invalid entry. Otherwise it replaces the least recently used entry, where both a refill and a hit count as a use.
- R7: When both sides miss in the same cycle, the data side answers at +2 cycles and the instruction side at +5 cycles.
- R8: Any write through the table write port empties both shadows. The next access to a previously cached page takes the two-cycle unified path.
- R9: Any change of `vm_en` empties both shadows.
- R10: A table write stores the tag, real page and valid bit at `tw_idx`. An entry whose valid bit is 0 never matches, and rewriting an index replaces its old mapping. When several entries match, the lowest index wins.
- R11: While the walker serves one side, shadow hits on the other side still answer in the same cycle.
- R12: After reset both shadows are empty, the walker is in `ST_IDLE`, and with no request all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vm_en | input | 1 | Translation enable |
| i_req_valid | input | 1 | Instruction-side request present |
| i_req_ea | input | 32 | Instruction-side effective address |
| i_rsp_done | output | 1 | Instruction-side translation delivered |
| i_rsp_miss | output | 1 | Instruction-side TLB miss exception |
| i_rsp_ra | output | 32 | Instruction-side real address |
| d_req_valid | input | 1 | Data-side request present |
| d_req_ea | input | 32 | Data-side effective address |
| d_rsp_done | output | 1 | Data-side translation delivered |
| d_rsp_miss | output | 1 | Data-side TLB miss exception |
| d_rsp_ra | output | 32 | Data-side real address |
| tw_en | input | 1 | Unified TLB write strobe |
| tw_idx | input | 4 | Unified TLB entry index |
| tw_valid | input | 1 | Valid bit written to the entry |
| tw_vpn | input | 20 | Virtual page tag written to the entry |
| tw_rpn | input | 20 | Real page written to the entry |

## Verification
A table of accesses alternates between pages that should hit in a shadow, pages that need the unified walk, and pages absent or invalid in the unified TLB. For each access the bench measures the response latency, which separates the zero-cycle shadow path from the two-cycle walk, and checks the returned real page, which separates a shadow answer from a unified one. A sequence of five distinct pages on one side, with interleaved re-hits, shows which entry the LRU policy evicts. The same pages on the other side show that the shadows are separate. Directed tests cover:
- two simultaneous misses, which probe the arbitration order and hit service during a walk;
- a table rewrite, which probes both the flush and the new mapping;
- an enable toggle, which probes the second flush trigger.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam int PAGE_W = ADDR_W - OFF_W;

    localparam logic SIDE_I = 1'b0;
    localparam logic SIDE_D = 1'b1;

    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        logic  vld;
        page_t vpn;
        page_t rpn;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_RESP = 2'd2
    } walk_st_e;
endpackage

// File: rtl/xlt_shadow.sv
module xlt_shadow
    import xlt_pkg::*;
#(
    parameter int N = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  page_t lk_vpn,
    input  logic  touch,
    output logic  lk_hit,
    output page_t lk_rpn,
    input  logic  fill,
    input  page_t fill_vpn,
    input  page_t fill_rpn
);
    localparam int AW = (N > 1) ? $clog2(N) : 1;

    tlb_ent_t       ent [N];
    logic [AW-1:0]  age [N];
    logic [N-1:0]   hit_vec;
    logic [N-1:0]   vld_vec;
    logic [AW-1:0]  hit_idx;
    logic [AW-1:0]  vic_idx;
    logic [AW-1:0]  use_idx;
    logic           do_use;

    for (genvar k = 0; k < N; k++) begin : g_cmp
        assign hit_vec[k] = ent[k].vld && (ent[k].vpn == lk_vpn);
        assign vld_vec[k] = ent[k].vld;
    end

    always_comb begin
        lk_rpn  = '0;
        hit_idx = '0;
        for (int k = 0; k < N; k++) begin
            if (hit_vec[k]) begin
                lk_rpn  = ent[k].rpn;
                hit_idx = AW'(k);
            end
        end
    end
    assign lk_hit = |hit_vec;

    // victim: lowest invalid entry, else the oldest one
    always_comb begin
        vic_idx = '0;
        for (int k = 0; k < N; k++) begin
            if (age[k] == AW'(N - 1)) vic_idx = AW'(k);
        end
        for (int k = N - 1; k >= 0; k--) begin
            if (!ent[k].vld) vic_idx = AW'(k);
        end
    end

    assign do_use  = fill | (touch & lk_hit);
    assign use_idx = fill ? vic_idx : hit_idx;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int k = 0; k < N; k++) begin
                ent[k] <= '0;
                age[k] <= AW'(k);
            end
        end else begin
            for (int k = 0; k < N; k++) begin
                if (fill && (AW'(k) == vic_idx)) begin
                    ent[k] <= '{vld: 1'b1, vpn: fill_vpn, rpn: fill_rpn};
                end
                if (do_use) begin
                    if (AW'(k) == use_idx)         age[k] <= '0;
                    else if (age[k] < age[use_idx]) age[k] <= age[k] + 1'b1;
                end
            end
        end
    end

    logic [N-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int k = 0; k < N; k++) age_seen[age[k]] = 1'b1;
    end

    // R6
    lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(age_seen) == N);

    // R2
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_vec == '0));
endmodule

// File: rtl/xlt_utlb.sv
module xlt_utlb
    import xlt_pkg::*;
#(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_vld,
    input  page_t         wr_vpn,
    input  page_t         wr_rpn,
    input  page_t         lk_vpn,
    output logic          lk_hit,
    output page_t         lk_rpn
);
    tlb_ent_t     ent [N];
    logic [N-1:0] match;

    for (genvar k = 0; k < N; k++) begin : g_cmp
        assign match[k] = ent[k].vld && (ent[k].vpn == lk_vpn);
    end

    // lowest matching index wins
    always_comb begin
        lk_rpn = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (match[k]) lk_rpn = ent[k].rpn;
        end
    end
    assign lk_hit = |match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) ent[k] <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < N; k++) begin
                if (IW'(k) == wr_idx) begin
                    ent[k] <= '{vld: wr_vld, vpn: wr_vpn, rpn: wr_rpn};
                end
            end
        end
    end

    // R10
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent[$past(wr_idx)].vld == $past(wr_vld))
               && (ent[$past(wr_idx)].rpn == $past(wr_rpn)));
endmodule

// File: rtl/xlt_walker.sv
module xlt_walker
    import xlt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic [1:0] need,
    input  page_t      vpn_in [2],
    output page_t      ut_vpn,
    input  logic       ut_hit,
    input  page_t      ut_rpn,
    output logic [1:0] busy,
    output logic [1:0] done,
    output logic [1:0] miss,
    output logic [1:0] fill,
    output page_t      rsp_rpn,
    output page_t      fill_vpn
);
    walk_st_e st_q, st_nx;
    logic     side_q;
    page_t    vpn_q;
    page_t    rpn_q;
    logic     hit_q;
    logic     stale_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: if (|need) st_nx = ST_LOOK;
            ST_LOOK: st_nx = ST_RESP;
            ST_RESP: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_q  <= SIDE_I;
            vpn_q   <= '0;
            rpn_q   <= '0;
            hit_q   <= 1'b0;
            stale_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    side_q  <= need[SIDE_D] ? SIDE_D : SIDE_I;
                    vpn_q   <= need[SIDE_D] ? vpn_in[SIDE_D] : vpn_in[SIDE_I];
                    stale_q <= 1'b0;
                end
                ST_LOOK: begin
                    hit_q   <= ut_hit;
                    rpn_q   <= ut_rpn;
                    stale_q <= flush;
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy = '0;
        done = '0;
        miss = '0;
        fill = '0;
        unique case (st_q)
            ST_IDLE: ;
            ST_LOOK: busy[side_q] = 1'b1;
            ST_RESP: begin
                busy[side_q] = 1'b1;
                done[side_q] = hit_q;
                miss[side_q] = ~hit_q;
                fill[side_q] = hit_q & ~stale_q & ~flush;
            end
            default: ;
        endcase
    end

    assign ut_vpn   = vpn_q;
    assign rsp_rpn  = rpn_q;
    assign fill_vpn = vpn_q;

    // R3
    look_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOOK) |=> (st_q == ST_RESP));

    // R3
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESP) |=> (st_q == ST_IDLE));

    // R7
    data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && need[SIDE_D]) |=> (side_q == SIDE_D && vpn_q == $past(vpn_in[SIDE_D])));

    // R4
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done & miss) == 2'b00);
endmodule

// File: rtl/xlt_translator.sv
module xlt_translator
    import xlt_pkg::*;
#(
    parameter int SH_ENTRIES = 4,
    parameter int UT_ENTRIES = 16,
    parameter int UT_IW      = (UT_ENTRIES > 1) ? $clog2(UT_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vm_en,
    input  logic              i_req_valid,
    input  logic [ADDR_W-1:0] i_req_ea,
    output logic              i_rsp_done,
    output logic              i_rsp_miss,
    output logic [ADDR_W-1:0] i_rsp_ra,
    input  logic              d_req_valid,
    input  logic [ADDR_W-1:0] d_req_ea,
    output logic              d_rsp_done,
    output logic              d_rsp_miss,
    output logic [ADDR_W-1:0] d_rsp_ra,
    input  logic              tw_en,
    input  logic [UT_IW-1:0]  tw_idx,
    input  logic              tw_valid,
    input  logic [PAGE_W-1:0] tw_vpn,
    input  logic [PAGE_W-1:0] tw_rpn
);
    logic              vm_q;
    logic              flush;
    logic [1:0]        req_v;
    logic [ADDR_W-1:0] req_ea  [2];
    page_t             req_vpn [2];
    page_t             sh_rpn  [2];
    logic [ADDR_W-1:0] rsp_ra  [2];
    logic [1:0]        sh_hit, need, busy, w_done, w_miss, fill;
    logic [1:0]        rsp_done, rsp_miss;
    page_t             ut_vpn, ut_rpn, w_rpn, fill_vpn;
    logic              ut_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) vm_q <= 1'b0;
        else        vm_q <= vm_en;
    end
    assign flush = tw_en | (vm_en != vm_q);

    assign req_v          = {d_req_valid, i_req_valid};
    assign req_ea[SIDE_I] = i_req_ea;
    assign req_ea[SIDE_D] = d_req_ea;

    for (genvar s = 0; s < 2; s++) begin : g_side
        assign req_vpn[s] = req_ea[s][ADDR_W-1:OFF_W];

        xlt_shadow #(.N(SH_ENTRIES)) u_shadow (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .lk_vpn   (req_vpn[s]),
            .touch    (req_v[s] & vm_en & ~busy[s]),
            .lk_hit   (sh_hit[s]),
            .lk_rpn   (sh_rpn[s]),
            .fill     (fill[s]),
            .fill_vpn (fill_vpn),
            .fill_rpn (w_rpn)
        );

        assign need[s]     = req_v[s] & vm_en & ~sh_hit[s] & ~busy[s];
        assign rsp_done[s] = req_v[s] & (busy[s] ? w_done[s] : (~vm_en | sh_hit[s]));
        assign rsp_miss[s] = req_v[s] & busy[s] & w_miss[s];
        assign rsp_ra[s]   = busy[s] ? {w_rpn, req_ea[s][OFF_W-1:0]}
                           : (vm_en ? {sh_rpn[s], req_ea[s][OFF_W-1:0]} : req_ea[s]);
    end

    xlt_utlb #(.N(UT_ENTRIES), .IW(UT_IW)) u_utlb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tw_en),
        .wr_idx (tw_idx),
        .wr_vld (tw_valid),
        .wr_vpn (tw_vpn),
        .wr_rpn (tw_rpn),
        .lk_vpn (ut_vpn),
        .lk_hit (ut_hit),
        .lk_rpn (ut_rpn)
    );

    xlt_walker u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .need     (need),
        .vpn_in   (req_vpn),
        .ut_vpn   (ut_vpn),
        .ut_hit   (ut_hit),
        .ut_rpn   (ut_rpn),
        .busy     (busy),
        .done     (w_done),
        .miss     (w_miss),
        .fill     (fill),
        .rsp_rpn  (w_rpn),
        .fill_vpn (fill_vpn)
    );

    assign i_rsp_done = rsp_done[SIDE_I];
    assign i_rsp_miss = rsp_miss[SIDE_I];
    assign i_rsp_ra   = rsp_ra[SIDE_I];
    assign d_rsp_done = rsp_done[SIDE_D];
    assign d_rsp_miss = rsp_miss[SIDE_D];
    assign d_rsp_ra   = rsp_ra[SIDE_D];

    // R1
    pass_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_rsp_done | i_rsp_miss) |-> (i_rsp_ra[OFF_W-1:0] == i_req_ea[OFF_W-1:0]));

    // R4
    miss_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[SIDE_D] && d_req_valid) |=> (!busy[SIDE_D] || $stable(d_req_ea)));
endmodule

// File: tb/xlt_translator_bench.sv
`timescale 1ns/1ps
module xlt_translator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vm_en = 1'b0;
    logic        i_req_valid = 1'b0;
    logic [31:0] i_req_ea = '0;
    logic        i_rsp_done, i_rsp_miss;
    logic [31:0] i_rsp_ra;
    logic        d_req_valid = 1'b0;
    logic [31:0] d_req_ea = '0;
    logic        d_rsp_done, d_rsp_miss;
    logic [31:0] d_rsp_ra;
    logic        tw_en = 1'b0;
    logic [3:0]  tw_idx = '0;
    logic        tw_valid = 1'b0;
    logic [19:0] tw_vpn = '0;
    logic [19:0] tw_rpn = '0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  ended = 1'b0;

    always #2 clk = ~clk;

    xlt_translator u_xlt_translator (
        .clk(clk), .rst_n(rst_n), .vm_en(vm_en),
        .i_req_valid(i_req_valid), .i_req_ea(i_req_ea),
        .i_rsp_done(i_rsp_done), .i_rsp_miss(i_rsp_miss), .i_rsp_ra(i_rsp_ra),
        .d_req_valid(d_req_valid), .d_req_ea(d_req_ea),
        .d_rsp_done(d_rsp_done), .d_rsp_miss(d_rsp_miss), .d_rsp_ra(d_rsp_ra),
        .tw_en(tw_en), .tw_idx(tw_idx), .tw_valid(tw_valid),
        .tw_vpn(tw_vpn), .tw_rpn(tw_rpn)
    );

    // {side(0=I,1=D), vpn, kind(0 shadow hit, 1 walk hit, 2 walk miss)}
    localparam logic [22:0] VEC [20] = '{
        {1'b0, 20'h00010, 2'd1},  // R3 first access walks
        {1'b0, 20'h00010, 2'd0},  // R3 refilled -> hit
        {1'b1, 20'h00010, 2'd1},  // R5 other side still walks
        {1'b1, 20'h00010, 2'd0},  // R2
        {1'b0, 20'h00011, 2'd1},
        {1'b0, 20'h00012, 2'd1},
        {1'b0, 20'h00013, 2'd1},  // R6 shadow now full
        {1'b0, 20'h00010, 2'd0},  // R6 use 10, LRU becomes 11
        {1'b0, 20'h00014, 2'd1},  // R6 evicts 11
        {1'b0, 20'h00010, 2'd0},  // R6 10 kept
        {1'b0, 20'h00011, 2'd1},  // R6 11 was evicted; evicts 12
        {1'b0, 20'h00013, 2'd0},
        {1'b0, 20'h00012, 2'd1},  // R6 evicts 14
        {1'b0, 20'h00010, 2'd0},
        {1'b0, 20'h00014, 2'd1},  // R6 14 was evicted
        {1'b0, 20'h0004C, 2'd2},  // R10 invalid entry never matches
        {1'b0, 20'h0004C, 2'd2},  // R4 no refill after miss
        {1'b1, 20'h00099, 2'd2},  // R4 data-side miss
        {1'b1, 20'h00011, 2'd1},
        {1'b1, 20'h00011, 2'd0}
    };

    function automatic logic [19:0] map_rpn(input logic [19:0] vpn);
        return 20'h00800 + (vpn - 20'h00010) * 3;
    endfunction

    task automatic report(input bit ok, input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tbl_write(input logic [3:0] idx, input logic vld,
                             input logic [19:0] vpn, input logic [19:0] rpn);
        @(negedge clk);
        tw_en = 1'b1; tw_idx = idx; tw_valid = vld; tw_vpn = vpn; tw_rpn = rpn;
        @(posedge clk); #1;
        tw_en = 1'b0;
    endtask

    // exp_lat packs latency, exp_miss the exception; checks ra when no miss
    task automatic access(input bit side, input logic [19:0] vpn, input logic [11:0] off,
                          input int exp_lat, input bit exp_miss, input logic [31:0] exp_ra,
                          input string req);
        int lat;
        bit got_done, got_miss;
        logic [31:0] ra;
        @(negedge clk);
        if (side) begin d_req_valid = 1'b1; d_req_ea = {vpn, off}; end
        else      begin i_req_valid = 1'b1; i_req_ea = {vpn, off}; end
        lat = 0;
        #1;
        got_done = side ? d_rsp_done : i_rsp_done;
        got_miss = side ? d_rsp_miss : i_rsp_miss;
        ra       = side ? d_rsp_ra   : i_rsp_ra;
        while (!got_done && !got_miss && lat < 12) begin
            @(negedge clk); #1;
            lat++;
            got_done = side ? d_rsp_done : i_rsp_done;
            got_miss = side ? d_rsp_miss : i_rsp_miss;
            ra       = side ? d_rsp_ra   : i_rsp_ra;
        end
        report(lat == exp_lat, req, "latency", 64'(lat), 64'(exp_lat));
        report(got_miss == exp_miss && got_done == !exp_miss, req, "done/miss",
               {62'd0, got_done, got_miss}, {62'd0, !exp_miss, exp_miss});
        if (!exp_miss) report(ra == exp_ra, req, "real address", 64'(ra), 64'(exp_ra));
        @(posedge clk); #1;
        i_req_valid = 1'b0; d_req_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!ended) begin
            ended = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R12 reset state
        report({i_rsp_done, i_rsp_miss, d_rsp_done, d_rsp_miss} == 4'b0, "R12", "idle outputs",
               64'({i_rsp_done, i_rsp_miss, d_rsp_done, d_rsp_miss}), 64'd0);

        for (int k = 0; k < 16; k++) begin
            if (k < 12) tbl_write(4'(k), 1'b1, 20'h00010 + 20'(k), map_rpn(20'h00010 + 20'(k)));
            else        tbl_write(4'(k), 1'b0, 20'h00040 + 20'(k), 20'h00F00 + 20'(k));
        end

        // R1 pass-through on both sides
        access(1'b0, 20'h00010, 12'h5A5, 0, 1'b0, {20'h00010, 12'h5A5}, "R1");
        access(1'b1, 20'hABCDE, 12'h001, 0, 1'b0, {20'hABCDE, 12'h001}, "R1");

        @(negedge clk); vm_en = 1'b1;

        for (int v = 0; v < 20; v++) begin
            logic [11:0] off;
            int kind;
            off  = 12'h123 + 12'(v * 37);
            kind = int'(VEC[v][1:0]);
            access(VEC[v][22], VEC[v][21:2], off, (kind == 0) ? 0 : 2, kind == 2,
                   {map_rpn(VEC[v][21:2]), off},
                   kind == 0 ? "R2" : (kind == 1 ? "R3" : "R4"));
        end

        // R7 both miss together; R11 data hits during instruction walk
        begin
            int dc, ic;
            bit d4;
            logic [31:0] dra, ira;
            dc = -1; ic = -1; d4 = 1'b0; dra = '0; ira = '0;
            @(negedge clk);
            i_req_valid = 1'b1; i_req_ea = {20'h00015, 12'h0AB};
            d_req_valid = 1'b1; d_req_ea = {20'h00016, 12'h0CD};
            for (int c = 0; c < 12; c++) begin
                #1;
                if (d_rsp_done && dc < 0) begin dc = c; dra = d_rsp_ra; end
                if (c == 4) d4 = d_rsp_done;
                if ((i_rsp_done || i_rsp_miss) && ic < 0) begin ic = c; ira = i_rsp_ra; end
                if (ic >= 0) break;
                @(negedge clk);
            end
            @(posedge clk); #1;
            i_req_valid = 1'b0; d_req_valid = 1'b0;
            report(dc == 2, "R7", "data latency", 64'(dc), 64'd2);
            report(ic == 5, "R7", "instr latency", 64'(ic), 64'd5);
            report(dra == {map_rpn(20'h00016), 12'h0CD}, "R7", "data ra", 64'(dra),
                   64'({map_rpn(20'h00016), 12'h0CD}));
            report(ira == {map_rpn(20'h00015), 12'h0AB}, "R7", "instr ra", 64'(ira),
                   64'({map_rpn(20'h00015), 12'h0AB}));
            report(d4, "R11", "data hit during walk", 64'(d4), 64'd1);
        end

        // R8 and R10: rewrite entry 0 flushes both shadows and remaps
        tbl_write(4'd0, 1'b1, 20'h00010, 20'h00777);
        access(1'b0, 20'h00010, 12'h010, 2, 1'b0, {20'h00777, 12'h010}, "R8");
        access(1'b1, 20'h00011, 12'h020, 2, 1'b0, {map_rpn(20'h00011), 12'h020}, "R8");
        access(1'b0, 20'h00010, 12'h030, 0, 1'b0, {20'h00777, 12'h030}, "R10");

        // R9: enable toggle flushes
        @(negedge clk); vm_en = 1'b0;
        access(1'b0, 20'h00010, 12'h040, 0, 1'b0, {20'h00010, 12'h040}, "R1");
        @(negedge clk); vm_en = 1'b1;
        access(1'b0, 20'h00010, 12'h050, 2, 1'b0, {20'h00777, 12'h050}, "R9");
        access(1'b1, 20'h00011, 12'h060, 2, 1'b0, {map_rpn(20'h00011), 12'h060}, "R9");

        // R10 duplicate tag: lowest index wins
        tbl_write(4'd9, 1'b1, 20'h00010, 20'h00333);
        access(1'b1, 20'h00010, 12'h070, 2, 1'b0, {20'h00777, 12'h070}, "R10");

        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule